// File: doc/BRIEF.md
# Hierarchical Coherence Directory Node

This block is one level of directory in a tree of cache-only memories. It sits between a lower split-transaction bus that serves its children and an upper bus toward the root. For every item it tracks a state and an address tag, and it never stores data. On each operation it decides one of three outcomes: the operation is settled inside its own subtree, it is forwarded upward, or it is turned back downward.

Lookups finish in the cycle an operation is accepted. The state update and the outgoing operation take effect at that same clock edge. Each direction of output has a one-entry queue with a valid/ready handshake. A configuration input marks the node as the root of the tree. The root answers erases with an exclusive acknowledge and turns replacement outs into injects, where a lower node would forward them upward. The directory is direct-mapped: the low address bits select an entry and the remaining bits form the tag.

Top module: `cohdir_node`

## Requirements
- R1: After reset both output valids are low, both input readies are high, and every entry is invalid.
- R2: Operation codes are READ=0, DATA=1, ERASE=2, ACK=3, OUT=4, INJECT=5. A READ from below for an item not held in the subtree appears once on the upper output as READ with the same address, and the item becomes Reading.
- R3: A further READ from below while the item is Reading is merged and produces no output. A DATA from above then produces exactly one DATA on the lower output and leaves the item Shared, so a later READ from below produces no output.
- R4: A READ from above for a Shared item produces READ on the lower output and moves the item to Answering. A DATA from below then produces DATA on the upper output and returns the item to Shared.
- R5: On a node that is not the root, an ERASE from below for a Shared item produces ERASE on the upper output and the item becomes Waiting. An ACK from above then produces ACK on the lower output and the item becomes Exclusive. A later ERASE from below for that Exclusive item produces ACK on the lower output and nothing upward.
- R6: An ERASE from below that arrives while the item is Waiting loses the race. It is returned as ERASE on the lower output with the same address, and nothing goes upward.
- R7: An ERASE from above for a held item produces ERASE on the lower output and invalidates the item, so a later READ from below is forwarded upward.
- R8: An OUT from below is absorbed, with no output, when the item is Shared, Reading, Answering, Waiting or Reading-and-Waiting. When the item is Exclusive or invalid on a node that is not the root, the OUT is forwarded upward and the item becomes invalid.
- R9: On the root node, nothing is ever sent upward. An OUT from below produces INJECT on the lower output, and an ERASE from below produces ACK on the lower output.
- R10: An INJECT from above for an invalid item produces INJECT on the lower output and makes the item Shared, so a later READ from below produces no output.
- R11: An output whose valid is high and whose ready is low keeps valid, op and address unchanged, and no input is accepted while that queue is full. When both inputs are valid, the upper input is taken first and the lower ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_top | input | 1 | Node is the root of the tree |
| lo_valid | input | 1 | Operation from the child bus is valid |
| lo_ready | output | 1 | Child-bus operation accepted this cycle |
| lo_op | input | 3 | Child-bus operation code |
| lo_addr | input | ADDR_W | Child-bus item address |
| hi_valid | input | 1 | Operation from the parent bus is valid |
| hi_ready | output | 1 | Parent-bus operation accepted this cycle |
| hi_op | input | 3 | Parent-bus operation code |
| hi_addr | input | ADDR_W | Parent-bus item address |
| up_valid | output | 1 | Outgoing upward operation valid |
| up_ready | input | 1 | Parent bus takes the upward operation |
| up_op | output | 3 | Upward operation code |
| up_addr | output | ADDR_W | Upward item address |
| dn_valid | output | 1 | Outgoing downward operation valid |
| dn_ready | input | 1 | Child bus takes the downward operation |
| dn_op | output | 3 | Downward operation code |
| dn_addr | output | ADDR_W | Downward item address |

## Verification
One item is taken through a full life cycle in every state: a miss read, a merged read, a fill, an answer upward, a write race, an acknowledge, an eviction and an invalidation from above. After each step, the presence or absence of output shows which of the absorb, forward or bounce outcomes the directory chose. Separate items check the inject path and the root conversions. A held-off output shows that the queue keeps its content stable and blocks input. Valids driven on both inputs together show the priority of the upper input.

// File: rtl/cohdir_pkg.sv
package cohdir_pkg;
  typedef enum logic [2:0] {
    OP_READ = 3'd0, OP_DATA = 3'd1, OP_ERASE = 3'd2,
    OP_ACK = 3'd3, OP_OUT = 3'd4, OP_INJECT = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    ST_INV = 3'd0, ST_SHR = 3'd1, ST_EXC = 3'd2, ST_RDG = 3'd3,
    ST_ANS = 3'd4, ST_WT = 3'd5, ST_RDW = 3'd6
  } st_e;
endpackage

// File: rtl/cohdir_tags.sv
module cohdir_tags
  import cohdir_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output st_e               lk_state,
  input  logic              wr_en,
  input  st_e               wr_state
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  st_e              state_q [DEPTH];
  logic [TAG_W-1:0] tag_q   [DEPTH];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  assign idx = lk_addr[IDX_W-1:0];
  assign tag = lk_addr[ADDR_W-1:IDX_W];

  always_comb begin
    if (state_q[idx] != ST_INV && tag_q[idx] == tag) lk_state = state_q[idx];
    else lk_state = ST_INV;
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic hit_wr;
      assign hit_wr = wr_en && (idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q[g] <= ST_INV;
        else if (hit_wr) state_q[g] <= wr_state;
      end
      always_ff @(posedge clk) begin
        if (hit_wr) tag_q[g] <= tag;
      end
    end
  endgenerate
endmodule

// File: rtl/cohdir_proto.sv
module cohdir_proto
  import cohdir_pkg::*;
(
  input  logic from_hi,
  input  logic is_top,
  input  op_e  op,
  input  st_e  cur,
  output st_e  nxt,
  output logic up_push,
  output op_e  up_op,
  output logic dn_push,
  output op_e  dn_op
);
  always_comb begin
    nxt     = cur;
    up_push = 1'b0;
    up_op   = op;
    dn_push = 1'b0;
    dn_op   = op;
    if (from_hi) begin
      unique case (op)
        OP_READ: if (cur == ST_SHR || cur == ST_EXC) begin
          nxt = ST_ANS; dn_push = 1'b1;
        end
        OP_DATA: if (cur == ST_RDG || cur == ST_RDW) begin
          nxt = (cur == ST_RDG) ? ST_SHR : ST_WT; dn_push = 1'b1;
        end
        OP_ERASE: if (cur != ST_INV) begin
          nxt = (cur == ST_WT) ? ST_RDW : ST_INV; dn_push = 1'b1;
        end
        OP_ACK: if (cur == ST_WT) begin
          nxt = ST_EXC; dn_push = 1'b1;
        end
        OP_INJECT: if (cur == ST_INV) begin
          nxt = ST_SHR; dn_push = 1'b1;
        end
        default: ;
      endcase
    end else begin
      unique case (op)
        OP_READ: begin
          if (cur == ST_EXC) nxt = ST_SHR;
          else if (cur == ST_INV) begin
            nxt = ST_RDG; up_push = !is_top;
          end
        end
        OP_DATA: if (cur == ST_ANS) begin
          nxt = ST_SHR; up_push = !is_top;
        end
        OP_ERASE: begin
          if (cur == ST_EXC) begin
            dn_push = 1'b1; dn_op = OP_ACK;
          end else if (cur == ST_WT || cur == ST_RDW) begin
            dn_push = 1'b1;
          end else if (is_top) begin
            nxt = ST_EXC; dn_push = 1'b1; dn_op = OP_ACK;
          end else begin
            nxt = (cur == ST_RDG) ? ST_RDW : ST_WT; up_push = 1'b1;
          end
        end
        OP_OUT: if (cur == ST_INV || cur == ST_EXC) begin
          if (is_top) begin
            dn_push = 1'b1; dn_op = OP_INJECT;
          end else begin
            nxt = ST_INV; up_push = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cohdir_oq.sv
module cohdir_oq #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         free,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic v_d;

  assign free = !out_valid || out_ready;

  always_comb begin
    v_d = out_valid && !out_ready;
    if (push) v_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else out_valid <= v_d;
  end

  always_ff @(posedge clk) begin
    if (push) out_data <= push_data;
  end

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/cohdir_node.sv
module cohdir_node
  import cohdir_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_top,
  input  logic              lo_valid,
  output logic              lo_ready,
  input  logic [2:0]        lo_op,
  input  logic [ADDR_W-1:0] lo_addr,
  input  logic              hi_valid,
  output logic              hi_ready,
  input  logic [2:0]        hi_op,
  input  logic [ADDR_W-1:0] hi_addr,
  output logic              up_valid,
  input  logic              up_ready,
  output logic [2:0]        up_op,
  output logic [ADDR_W-1:0] up_addr,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [2:0]        dn_op,
  output logic [ADDR_W-1:0] dn_addr
);
  localparam int QW = 3 + ADDR_W;

  logic rs_q1, rs_q2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  logic              up_free, dn_free, all_free, fire;
  logic [ADDR_W-1:0] cur_addr;
  op_e               cur_op;
  st_e               lk_state, nxt_state;
  logic              up_push, dn_push;
  op_e               up_op_c, dn_op_c;
  logic [QW-1:0]     up_q, dn_q;

  assign all_free = up_free && dn_free && rs_q2;
  assign hi_ready = all_free;
  assign lo_ready = all_free && !hi_valid;
  assign fire     = all_free && (hi_valid || lo_valid);
  assign cur_op   = op_e'(hi_valid ? hi_op : lo_op);
  assign cur_addr = hi_valid ? hi_addr : lo_addr;

  cohdir_tags #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) tags_i (
    .clk(clk), .rst_n(rs_q2), .lk_addr(cur_addr), .lk_state(lk_state),
    .wr_en(fire && nxt_state != lk_state), .wr_state(nxt_state)
  );

  cohdir_proto proto_i (
    .from_hi(hi_valid), .is_top(is_top), .op(cur_op), .cur(lk_state),
    .nxt(nxt_state), .up_push(up_push), .up_op(up_op_c),
    .dn_push(dn_push), .dn_op(dn_op_c)
  );

  cohdir_oq #(.W(QW)) upq_i (
    .clk(clk), .rst_n(rs_q2), .push(fire && up_push),
    .push_data({up_op_c, cur_addr}), .free(up_free),
    .out_valid(up_valid), .out_ready(up_ready), .out_data(up_q)
  );

  cohdir_oq #(.W(QW)) dnq_i (
    .clk(clk), .rst_n(rs_q2), .push(fire && dn_push),
    .push_data({dn_op_c, cur_addr}), .free(dn_free),
    .out_valid(dn_valid), .out_ready(dn_ready), .out_data(dn_q)
  );

  assign up_op   = up_q[QW-1:ADDR_W];
  assign up_addr = up_q[ADDR_W-1:0];
  assign dn_op   = dn_q[QW-1:ADDR_W];
  assign dn_addr = dn_q[ADDR_W-1:0];

  // R3
  merge_read_chk: assert property (@(posedge clk) disable iff (!rs_q2)
    fire && !hi_valid && cur_op == OP_READ && lk_state == ST_RDG |=> !up_valid);
  // R6
  race_bounce_chk: assert property (@(posedge clk) disable iff (!rs_q2)
    fire && !hi_valid && cur_op == OP_ERASE && lk_state == ST_WT
    |=> dn_valid && dn_op == OP_ERASE && !up_valid);
  // R5
  ack_pass_chk: assert property (@(posedge clk) disable iff (!rs_q2)
    fire && hi_valid && cur_op == OP_ACK && lk_state == ST_WT
    |=> dn_valid && dn_op == OP_ACK);
  // R9
  root_silent_chk: assert property (@(posedge clk) disable iff (!rs_q2)
    is_top && $stable(is_top) && !up_valid |=> !up_valid);
endmodule

// File: tb/cohdir_node_tb_top.sv
module cohdir_node_tb_top;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n, is_top;
  logic lo_valid, lo_ready, hi_valid, hi_ready;
  logic [2:0] lo_op, hi_op, up_op, dn_op;
  logic [AW-1:0] lo_addr, hi_addr, up_addr, dn_addr;
  logic up_valid, up_ready, dn_valid, dn_ready;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [AW+3:0] exp_q[$];
  string req_q[$];

  always #10 clk = ~clk;

  cohdir_node dut_i (
    .clk(clk), .rst_n(rst_n), .is_top(is_top),
    .lo_valid(lo_valid), .lo_ready(lo_ready), .lo_op(lo_op), .lo_addr(lo_addr),
    .hi_valid(hi_valid), .hi_ready(hi_ready), .hi_op(hi_op), .hi_addr(hi_addr),
    .up_valid(up_valid), .up_ready(up_ready), .up_op(up_op), .up_addr(up_addr),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_op(dn_op), .dn_addr(dn_addr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected items as the design emits them (bit AW+3: 1=up)
  always @(negedge clk) begin
    if (rst_n) begin
      if (up_valid && up_ready) begin
        if (exp_q.size() == 0) check("unexpected-up", {1'b1, up_op, up_addr}, 0);
        else check(req_q.pop_front(), {1'b1, up_op, up_addr}, exp_q.pop_front());
      end
      if (dn_valid && dn_ready) begin
        if (exp_q.size() == 0) check("unexpected-dn", {1'b0, dn_op, dn_addr}, 0);
        else check(req_q.pop_front(), {1'b0, dn_op, dn_addr}, exp_q.pop_front());
      end
    end
  end

  task automatic send(bit from_hi, logic [2:0] op, logic [AW-1:0] a);
    @(negedge clk);
    if (from_hi) begin hi_valid = 1; hi_op = op; hi_addr = a; end
    else begin lo_valid = 1; lo_op = op; lo_addr = a; end
    while (!(from_hi ? hi_ready : lo_ready)) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    hi_valid = 0; lo_valid = 0;
  endtask

  task automatic expect_out(bit up, logic [2:0] op, logic [AW-1:0] a, string req);
    exp_q.push_back({up, op, a});
    req_q.push_back(req);
  endtask

  task automatic settle(string req);
    repeat (3) @(negedge clk);
    check({req, " pending"}, exp_q.size(), 0);
    exp_q.delete(); req_q.delete();
  endtask

  localparam logic [2:0] RD = 0, DT = 1, ER = 2, AK = 3, OT = 4, IJ = 5;
  localparam logic [AW-1:0] A = 16'h0011, B = 16'h0022, C = 16'h0033,
                            D = 16'h0044, E = 16'h0055, G = 16'h0066;

  initial begin
    rst_n = 0; is_top = 0; lo_valid = 0; hi_valid = 0;
    lo_op = 0; hi_op = 0; lo_addr = 0; hi_addr = 0;
    up_ready = 1; dn_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 up_valid", up_valid, 0);
    check("R1 dn_valid", dn_valid, 0);
    check("R1 lo_ready", lo_ready, 1);
    check("R1 hi_ready", hi_ready, 1);

    expect_out(1, RD, A, "R2 miss read up"); send(0, RD, A); settle("R2");
    send(0, RD, A); settle("R3 merged read");
    expect_out(0, DT, A, "R3 data down"); send(1, DT, A); settle("R3");
    send(0, RD, A); settle("R3 shared local read");
    expect_out(0, RD, A, "R4 read down"); send(1, RD, A); settle("R4");
    expect_out(1, DT, A, "R4 data up"); send(0, DT, A); settle("R4");
    send(0, OT, A); settle("R8 out absorbed shared");
    expect_out(1, ER, A, "R5 erase up"); send(0, ER, A); settle("R5");
    expect_out(0, ER, A, "R6 race bounce"); send(0, ER, A); settle("R6");
    send(0, OT, A); settle("R8 out absorbed waiting");
    expect_out(0, AK, A, "R5 ack down"); send(1, AK, A); settle("R5");
    expect_out(0, AK, A, "R5 local ack"); send(0, ER, A); settle("R5");
    expect_out(1, OT, A, "R8 out forwarded"); send(0, OT, A); settle("R8");
    expect_out(1, RD, A, "R8 invalid after out"); send(0, RD, A); settle("R8");
    expect_out(0, DT, A, "R3 refill"); send(1, DT, A); settle("R3");
    expect_out(0, ER, A, "R7 erase down"); send(1, ER, A); settle("R7");
    expect_out(1, RD, A, "R7 invalidated"); send(0, RD, A); settle("R7");
    expect_out(0, IJ, B, "R10 inject down"); send(1, IJ, B); settle("R10");
    send(0, RD, B); settle("R10 injected shared");

    // R11 stall
    up_ready = 0;
    expect_out(1, RD, C, "R11 held read");
    fork send(0, RD, C); join_none
    repeat (3) @(negedge clk);
    check("R11 up_valid held", up_valid, 1);
    check("R11 up_op held", up_op, RD);
    check("R11 up_addr held", up_addr, C);
    check("R11 lo_ready blocked", lo_ready, 0);
    up_ready = 1;
    settle("R11");

    // R11 priority: upper input first
    @(negedge clk);
    hi_valid = 1; hi_op = AK; hi_addr = G;
    lo_valid = 1; lo_op = RD; lo_addr = G;
    #1;
    check("R11 lo_ready low", lo_ready, 0);
    check("R11 hi_ready high", hi_ready, 1);
    expect_out(1, RD, G, "R11 lower after upper");
    @(posedge clk); @(negedge clk);
    hi_valid = 0;
    while (!lo_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    lo_valid = 0;
    settle("R11");

    // R9 root behaviour
    is_top = 1;
    expect_out(0, IJ, D, "R9 out to inject"); send(0, OT, D); settle("R9");
    expect_out(0, AK, E, "R9 root ack"); send(0, ER, E); settle("R9");
    expect_out(0, AK, E, "R9 exclusive ack"); send(0, ER, E); settle("R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule